// File: doc/BRIEF.md
# Hidden Register Unlock Sequencer

This block is the host-side register front end of a palette DAC. The host reaches it over a small parallel port: a 3-bit register select, separate read and write strobes, and 8-bit write and read data. Its main visible register is the 8-bit pixel mask. Behind that register sit an extended command register and a bank of indexed identification registers. Normal software cannot reach them.

The front end counts consecutive reads of the pixel-mask location. After exactly four such reads, the next pixel-mask write goes to the command register instead of the mask. After five or more reads, the next two pixel-mask writes load the index, low byte first and then high byte. Pixel-mask reads then return indexed bytes.

A second, direct path also exists. Dedicated selects load the index low and high bytes. A data select reads the byte at the current index, and every indexed data access advances the index by one. The indexed bank returns a vendor byte and a device byte at locations 0 and 1.

Top module: `palette_unlock_front`

## Requirements
- R1: After reset the pixel mask is FFh, the command register is 00h and the index is 0000h.
- R2: A pixel-mask write (select 2) that follows fewer than four consecutive pixel-mask reads updates the mask. A pixel-mask read returns the mask while the index-data mode of R10 is not active.
- R3: A read or write strobe on any select other than 2 clears the consecutive-read count. A read-count pattern broken this way leads only to a normal mask write.
- R4: A pixel-mask write that follows exactly four consecutive pixel-mask reads loads the command register and leaves the mask unchanged. The count then restarts, so the next pixel-mask write is a normal mask write.
- R5: After five or more consecutive pixel-mask reads, the next two pixel-mask writes load index bits 7:0 and then index bits 15:8. The mask is unchanged.
- R6: Indexed data is enabled only while command bit 4 is 1 (for example, value 10h). While command bit 4 is 0, indexed reads return 00h and the index does not advance.
- R7: With indexed data enabled, index 0000h reads 97h, index 0001h reads 03h, and every other index reads 00h.
- R8: A write to select 4 loads index bits 7:0 and a write to select 7 loads index bits 15:8. Reads of select 4 and select 7 return those bytes.
- R9: A read or write on select 5 returns or accesses the indexed byte. When enabled, it advances the index by one, wrapping from FFFFh to 0000h.
- R10: After the R5 index load, each pixel-mask read returns the indexed byte and advances the index (when enabled). A pixel-mask write, which is a normal mask write, ends this mode, and so does any access to another select.
- R11: A cycle with both strobes asserted has no effect and returns 00h.
- R12: Selects 0, 1, 3 and 6 read as 00h, and writes to them change neither the mask nor the command register.
- R13: Read data is 00h in every cycle without a read strobe. Read data is combinational and valid in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs | input | 3 | Register select |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read strobe |
| pix_mask | output | 8 | Current pixel mask |
| ext_cmd | output | 8 | Current extended command register |

## Verification
The assertions check the following on every cycle:
- read data is zero without a read strobe, on undefined selects and on colliding strobes;
- the mask and command registers change only after a pixel-mask write;
- indexed reads return only the two identification bytes or zero, and always zero while indexed data is disabled.

Only the bench scenarios can show the counted-read behaviour: the exact read counts that steer a write, the reset of the count by a foreign access, the low-then-high order of the index load, auto-increment with wrap, and the exit from index-data mode.

// File: rtl/puf_pkg.sv
package puf_pkg;

    localparam int unsigned DW    = 8;
    localparam int unsigned IDX_W = 2 * DW;

    localparam logic [2:0] RS_MASK     = 3'd2;
    localparam logic [2:0] RS_IDX_LO   = 3'd4;
    localparam logic [2:0] RS_IDX_DATA = 3'd5;
    localparam logic [2:0] RS_IDX_HI   = 3'd7;

    typedef enum logic [1:0] {
        SEQ_COUNT    = 2'd0,
        SEQ_IDX_HI   = 2'd1,
        SEQ_IDX_DATA = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/puf_seq.sv
module puf_seq
    import puf_pkg::*;
#(
    parameter int unsigned CMD_READS = 4,
    parameter int unsigned IDX_READS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       wr,
    input  logic [2:0] rs,
    output logic       mask_wr,
    output logic       cmd_wr,
    output logic       seq_lo_wr,
    output logic       seq_hi_wr,
    output logic       mask_idx_rd
);

    localparam int unsigned CNT_W = $clog2(IDX_READS + 1);
    localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_READS);
    localparam logic [CNT_W-1:0] CNT_IDX = CNT_W'(IDX_READS);

    typedef struct packed {
        seq_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        mask_wr     = 1'b0;
        cmd_wr      = 1'b0;
        seq_lo_wr   = 1'b0;
        seq_hi_wr   = 1'b0;
        mask_idx_rd = 1'b0;
        if (rd || wr) begin
            if (rs == RS_MASK) begin
                if (rd) begin
                    if (st_q.mode == SEQ_IDX_DATA) begin
                        mask_idx_rd = 1'b1;
                    end else begin
                        st_d.mode = SEQ_COUNT;
                        if (st_q.mode == SEQ_IDX_HI) begin
                            st_d.cnt = CNT_W'(1);
                        end else if (st_q.cnt >= CNT_IDX) begin
                            st_d.cnt = CNT_IDX;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end
                end else begin
                    st_d.cnt = '0;
                    case (st_q.mode)
                        SEQ_COUNT: begin
                            if (st_q.cnt == CNT_CMD) begin
                                cmd_wr = 1'b1;
                            end else if (st_q.cnt >= CNT_IDX) begin
                                seq_lo_wr = 1'b1;
                                st_d.mode = SEQ_IDX_HI;
                            end else begin
                                mask_wr = 1'b1;
                            end
                        end
                        SEQ_IDX_HI: begin
                            seq_hi_wr = 1'b1;
                            st_d.mode = SEQ_IDX_DATA;
                        end
                        default: begin
                            mask_wr   = 1'b1;
                            st_d.mode = SEQ_COUNT;
                        end
                    endcase
                end
            end else begin
                st_d.mode = SEQ_COUNT;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SEQ_COUNT, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/puf_index.sv
module puf_index
    import puf_pkg::*;
#(
    parameter logic [DW-1:0] VENDOR_ID = 8'h97,
    parameter logic [DW-1:0] DEVICE_ID = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic             step,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    id_byte
);

    localparam int unsigned N_ID = 2;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t ix_d, ix_q;
    logic [DW-1:0] id_tab [N_ID];

    assign id_tab[0] = VENDOR_ID;
    assign id_tab[1] = DEVICE_ID;

    always_comb begin
        ix_d = ix_q;
        if (lo_wr) begin
            ix_d.idx[DW-1:0] = wdata;
        end else if (hi_wr) begin
            ix_d.idx[IDX_W-1:DW] = wdata;
        end else if (step) begin
            ix_d.idx = ix_q.idx + IDX_W'(1);
        end
    end

    always_comb begin
        id_byte = '0;
        for (int i = 0; i < N_ID; i++) begin
            if (ix_q.idx == IDX_W'(i)) id_byte = id_tab[i];
        end
    end

    assign idx = ix_q.idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ix_q <= '0;
        end else begin
            ix_q <= ix_d;
        end
    end

endmodule

// File: rtl/palette_unlock_front.sv
module palette_unlock_front
    import puf_pkg::*;
#(
    parameter logic [DW-1:0] MASK_RESET = 8'hFF,
    parameter logic [DW-1:0] VENDOR_ID  = 8'h97,
    parameter logic [DW-1:0] DEVICE_ID  = 8'h03,
    parameter int unsigned   CMD_READS  = 4,
    parameter int unsigned   IDX_READS  = 5,
    parameter int unsigned   EN_BIT     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    rs,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] pix_mask,
    output logic [DW-1:0] ext_cmd
);

    typedef struct packed {
        logic [DW-1:0] mask;
        logic [DW-1:0] cmd;
    } reg_state_t;

    reg_state_t rg_d, rg_q;

    logic rd, wr;
    logic mask_wr, cmd_wr, seq_lo_wr, seq_hi_wr, mask_idx_rd;
    logic lo_wr, hi_wr, step, idx_en, data_acc;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0] id_byte;

    assign rd = rd_en && !wr_en;
    assign wr = wr_en && !rd_en;

    puf_seq #(
        .CMD_READS (CMD_READS),
        .IDX_READS (IDX_READS)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (rd),
        .wr          (wr),
        .rs          (rs),
        .mask_wr     (mask_wr),
        .cmd_wr      (cmd_wr),
        .seq_lo_wr   (seq_lo_wr),
        .seq_hi_wr   (seq_hi_wr),
        .mask_idx_rd (mask_idx_rd)
    );

    assign idx_en   = rg_q.cmd[EN_BIT];
    assign data_acc = (rd || wr) && (rs == RS_IDX_DATA);
    assign lo_wr    = seq_lo_wr || (wr && rs == RS_IDX_LO);
    assign hi_wr    = seq_hi_wr || (wr && rs == RS_IDX_HI);
    assign step     = idx_en && (data_acc || mask_idx_rd);

    puf_index #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) i_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .step    (step),
        .wdata   (wdata),
        .idx     (idx),
        .id_byte (id_byte)
    );

    always_comb begin
        rg_d = rg_q;
        if (mask_wr) rg_d.mask = wdata;
        if (cmd_wr)  rg_d.cmd  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '{mask: MASK_RESET, cmd: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (rs)
                RS_MASK:     rdata = mask_idx_rd ? (idx_en ? id_byte : '0) : rg_q.mask;
                RS_IDX_LO:   rdata = idx[DW-1:0];
                RS_IDX_HI:   rdata = idx[IDX_W-1:DW];
                RS_IDX_DATA: rdata = idx_en ? id_byte : '0;
                default:     rdata = '0;
            endcase
        end
    end

    assign pix_mask = rg_q.mask;
    assign ext_cmd  = rg_q.cmd;

endmodule

// File: rtl/puf_chk.sv
module puf_chk #(
    parameter logic [7:0] VENDOR_ID = 8'h97,
    parameter logic [7:0] DEVICE_ID = 8'h03,
    parameter int unsigned EN_BIT   = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rs,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] rdata,
    input logic [7:0] pix_mask,
    input logic [7:0] ext_cmd
);

    a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == 8'h00);

    a_r11_collide_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> ($stable(pix_mask) && $stable(ext_cmd)));

    a_r11_collide_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> rdata == 8'h00);

    a_r12_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (rs == 3'd0 || rs == 3'd1 || rs == 3'd3 || rs == 3'd6))
        |-> rdata == 8'h00);

    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !rd_en && rs == 3'd2) |=> $stable(pix_mask));

    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !rd_en && rs == 3'd2) |=> $stable(ext_cmd));

    a_r7_id_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rs == 3'd5)
        |-> (rdata == VENDOR_ID || rdata == DEVICE_ID || rdata == 8'h00));

    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rs == 3'd5 && !ext_cmd[EN_BIT]) |-> rdata == 8'h00);

endmodule

bind palette_unlock_front puf_chk #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .EN_BIT    (EN_BIT)
) i_chk (.*);

// File: tb/test_palette_unlock_front.sv
module test_palette_unlock_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rs = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pix_mask, ext_cmd;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    palette_unlock_front i_palette_unlock_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .rs       (rs),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .pix_mask (pix_mask),
        .ext_cmd  (ext_cmd)
    );

    // vector: {req[3:0], rd, wr, rs[2:0], wdata[7:0], expected[7:0], check}
    localparam int NV = 35;
    localparam logic [25:0] VEC [NV] = '{
        {4'd2,  1'b1, 1'b0, 3'd2, 8'h00, 8'hFF, 1'b1}, // R2 read reset mask
        {4'd2,  1'b0, 1'b1, 3'd2, 8'h5A, 8'h00, 1'b0}, // R2 plain write
        {4'd2,  1'b1, 1'b0, 3'd2, 8'h00, 8'h5A, 1'b1}, // R2
        {4'd3,  1'b1, 1'b0, 3'd2, 8'h00, 8'h5A, 1'b1},
        {4'd3,  1'b1, 1'b0, 3'd2, 8'h00, 8'h5A, 1'b1},
        {4'd12, 1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 1'b1}, // R12 / R3 breaks count
        {4'd3,  1'b1, 1'b0, 3'd2, 8'h00, 8'h5A, 1'b1},
        {4'd3,  1'b0, 1'b1, 3'd2, 8'h3C, 8'h00, 1'b0}, // R3 plain write
        {4'd3,  1'b1, 1'b0, 3'd2, 8'h00, 8'h3C, 1'b1},
        {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'h3C, 1'b1},
        {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'h3C, 1'b1},
        {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'h3C, 1'b1},
        {4'd4,  1'b0, 1'b1, 3'd2, 8'h10, 8'h00, 1'b0}, // R4 command write
        {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'h3C, 1'b1}, // R4 mask kept
        {4'd4,  1'b0, 1'b1, 3'd2, 8'hC3, 8'h00, 1'b0}, // R4 count restarted
        {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1},
        {4'd8,  1'b0, 1'b1, 3'd4, 8'h00, 8'h00, 1'b0}, // R8
        {4'd8,  1'b0, 1'b1, 3'd7, 8'h00, 8'h00, 1'b0},
        {4'd7,  1'b1, 1'b0, 3'd5, 8'h00, 8'h97, 1'b1}, // R7
        {4'd7,  1'b1, 1'b0, 3'd5, 8'h00, 8'h03, 1'b1},
        {4'd7,  1'b1, 1'b0, 3'd5, 8'h00, 8'h00, 1'b1},
        {4'd9,  1'b1, 1'b0, 3'd4, 8'h00, 8'h03, 1'b1}, // R9 index advanced
        {4'd8,  1'b1, 1'b0, 3'd7, 8'h00, 8'h00, 1'b1},
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1}, // R5
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1},
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1},
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1},
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1},
        {4'd5,  1'b1, 1'b0, 3'd2, 8'h00, 8'hC3, 1'b1}, // sixth read
        {4'd5,  1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 1'b0},
        {4'd5,  1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 1'b0},
        {4'd10, 1'b1, 1'b0, 3'd2, 8'h00, 8'h97, 1'b1}, // R10
        {4'd10, 1'b1, 1'b0, 3'd2, 8'h00, 8'h03, 1'b1},
        {4'd10, 1'b0, 1'b1, 3'd2, 8'h77, 8'h00, 1'b0}, // R10 exit by write
        {4'd10, 1'b1, 1'b0, 3'd2, 8'h00, 8'h77, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic acc(input logic r, input logic w, input logic [2:0] a,
                       input logic [7:0] d, output logic [7:0] got);
        rd_en = r;
        wr_en = w;
        rs    = a;
        wdata = d;
        #5;
        got = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] g;
        acc(1'b1, 1'b0, a, 8'h00, g);
        check(req, g, exp);
    endtask

    task automatic wr_do(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] g;
        acc(1'b0, 1'b1, a, d, g);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mask", pix_mask, 8'hFF);
        check("R1 cmd", ext_cmd, 8'h00);
        rd_chk("R1 idx lo", 3'd4, 8'h00);
        rd_chk("R1 idx hi", 3'd7, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            acc(v[21], v[20], v[19:17], v[16:9], g);
            if (v[0]) check($sformatf("R%0d vector %0d", v[25:22], i), g, v[8:1]);
        end
        check("R4 cmd loaded", ext_cmd, 8'h10);
        check("R10 mask after exit", pix_mask, 8'h77);

        // R5 low then high order through the mask pattern
        rd_chk("R12 select 3", 3'd3, 8'h00);
        for (int k = 0; k < 5; k++) rd_chk("R5 reads", 3'd2, 8'h77);
        wr_do(3'd2, 8'h34);
        wr_do(3'd2, 8'h12);
        check("R5 mask unchanged", pix_mask, 8'h77);
        check("R5 cmd unchanged", ext_cmd, 8'h10);
        rd_chk("R5 index low", 3'd4, 8'h34);
        rd_chk("R5 index high", 3'd7, 8'h12);

        // R9 wrap at the top of the index range
        wr_do(3'd4, 8'hFF);
        wr_do(3'd7, 8'hFF);
        rd_chk("R9 top index data", 3'd5, 8'h00);
        rd_chk("R9 wrap low", 3'd4, 8'h00);
        rd_chk("R9 wrap high", 3'd7, 8'h00);
        wr_do(3'd5, 8'hEE);
        rd_chk("R9 write steps index", 3'd4, 8'h01);

        // R11 colliding strobes
        acc(1'b1, 1'b1, 3'd2, 8'h11, g);
        check("R11 rdata", g, 8'h00);
        check("R11 mask", pix_mask, 8'h77);
        check("R11 cmd", ext_cmd, 8'h10);

        // R12 undefined selects
        wr_do(3'd0, 8'hAB);
        wr_do(3'd6, 8'hCD);
        check("R12 mask", pix_mask, 8'h77);
        check("R12 cmd", ext_cmd, 8'h10);
        rd_chk("R12 select 1", 3'd1, 8'h00);
        rd_chk("R12 select 6", 3'd6, 8'h00);

        // R6 disable through the command register
        for (int k = 0; k < 4; k++) rd_chk("R6 reads", 3'd2, 8'h77);
        wr_do(3'd2, 8'h00);
        check("R6 cmd cleared", ext_cmd, 8'h00);
        check("R6 mask kept", pix_mask, 8'h77);
        wr_do(3'd4, 8'h00);
        wr_do(3'd7, 8'h00);
        rd_chk("R6 data disabled", 3'd5, 8'h00);
        rd_chk("R6 no step", 3'd4, 8'h00);
        for (int k = 0; k < 5; k++) rd_chk("R6 reads", 3'd2, 8'h77);
        wr_do(3'd2, 8'h00);
        wr_do(3'd2, 8'h00);
        rd_chk("R6 mask data disabled", 3'd2, 8'h00);
        rd_chk("R6 mask path no step", 3'd4, 8'h00);

        // R13 no strobe
        acc(1'b0, 1'b0, 3'd5, 8'h00, g);
        check("R13 idle rdata", g, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule